// File: doc/BRIEF.md
# NAND Bad-Block Scanner and Table

After reset this block walks every block of a NAND array once and builds a table of which blocks are usable. It fetches the factory marker byte of each block through a single-byte read channel. It pulses a request with a block, page and column, and the channel later returns one byte with a valid strobe. The marker is the first byte of the spare area, at column 2048. A block is good only if that byte reads FFh, the erased value, on both page 0 and page 1. Page 1 is fetched only when page 0 reads FFh. A block that fails on page 0 is settled at once, and the scan moves on to the next block. Block 0 is guaranteed usable, so it is never read and always starts out good.

The table is one bit per block, held in flip-flops. A lookup port gives a registered answer one cycle after a block index is presented. Controllers use it to refuse erase or program on bad blocks. When a block later fails an erase or program, the controller reports it through a mark-bad input. A mark that arrives while the scan is still running is held in a single slot and written once the scan ends. A running count of bad blocks is output alongside the scan-done flag.

Top module: `bst_scanner`

## Requirements
- R1: After a synchronous active-high reset, `scan_done` is 0, `bad_count` is 0, `lk_bad` is 0 and every table entry is good. Block 0 is never read and stays good unless it is marked at run time.
- R2: `rd_req` is high for exactly one cycle per read and always carries column `SPARE_COL` (2048). `rd_block` and `rd_page` stay unchanged until `rd_rsp_valid` returns the byte.
- R3: Blocks are read in ascending order from block 1, and page 0 is read first. A page-0 byte other than 8'hFF makes the block bad, and the next request goes to page 0 of the next block.
- R4: When page 0 returns 8'hFF, the next request is page 1 of the same block. The block is bad exactly when that byte differs from 8'hFF.
- R5: `scan_done` rises in the cycle after the response that settles block `NUM_BLOCKS-1`. It then stays high until reset, and no further reads are issued.
- R6: `lk_bad` gives the table entry for the `lk_block` value sampled at the previous clock edge. A write on that same edge is not yet visible.
- R7: `bad_count` equals the number of bad entries. Marking a block that is already bad leaves the count unchanged.
- R8: Once `scan_done` is high and no mark is held, a `mark_valid` pulse sets the entry for `mark_block` at that clock edge. This includes block 0.
- R9: The first mark accepted during the scan is held and written in the first cycle after `scan_done` rises. Any other mark that arrives during the scan while the slot is full is dropped.
- R10: A reset during the scan clears the table, the count and any held mark, and restarts reading at page 0 of block 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | output | 1 | One-cycle read request pulse |
| rd_block | output | BLK_W | Block to read |
| rd_page | output | PAGE_W | Page within the block (0 or 1) |
| rd_col | output | COL_W | Byte column, always the spare-area marker |
| rd_rsp_valid | input | 1 | Returned byte is valid |
| rd_rsp_data | input | 8 | Returned byte |
| lk_block | input | BLK_W | Block index to look up |
| lk_bad | output | 1 | Registered lookup result, 1 = bad |
| mark_valid | input | 1 | Report a run-time failure |
| mark_block | input | BLK_W | Block that failed |
| scan_done | output | 1 | Scan complete |
| bad_count | output | CNT_W | Number of bad blocks in the table |

## Verification
The bench builds the block with 64 blocks, which gives a 6-bit index and a 7-bit count, and keeps the 2048 marker column on a 12-bit column bus. With so few blocks, two full scans and one interrupted scan fit in a few thousand cycles. This brings within reach the last-block settle and the `scan_done` edge, a mark held across that edge, and marks on block 0 and on an already-bad block. Response latency is varied from one to three cycles, so the requirement that the address stay stable is exercised on every read.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        SC_START,
        SC_ISSUE,
        SC_WAIT,
        SC_DONE
    } scan_state_e;

    // Outcome of one marker byte: whether the block is settled and how.
    typedef struct packed {
        logic settle;
        logic bad;
    } verdict_t;

    function automatic verdict_t judge_marker(input logic [7:0] marker,
                                              input logic       second_page);
        verdict_t r;
        r.bad    = (marker != ERASED_BYTE);
        r.settle = r.bad || second_page;
        return r;
    endfunction

endpackage

// File: rtl/bst_scan_seq.sv
module bst_scan_seq
    import bst_pkg::*;
#(
    parameter int NUM_BLOCKS = 1024,
    parameter int BLK_W      = 10,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int SPARE_COL  = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              rd_req,
    output logic [BLK_W-1:0]  rd_block,
    output logic [PAGE_W-1:0] rd_page,
    output logic [COL_W-1:0]  rd_col,
    output logic              set_en,
    output logic [BLK_W-1:0]  set_block,
    output logic              done
);

    localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);

    scan_state_e      state;
    logic [BLK_W-1:0] blk;
    logic             pg;
    verdict_t         vd;

    assign vd = judge_marker(rsp_data, pg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SC_START;
            blk   <= FIRST_BLK;
            pg    <= 1'b0;
        end else begin
            case (state)
                SC_START: state <= SC_ISSUE;
                SC_ISSUE: state <= SC_WAIT;
                SC_WAIT: begin
                    if (rsp_valid) begin
                        if (vd.settle) begin
                            if (blk == LAST_BLK) begin
                                state <= SC_DONE;
                            end else begin
                                blk   <= blk + FIRST_BLK;
                                pg    <= 1'b0;
                                state <= SC_ISSUE;
                            end
                        end else begin
                            pg    <= 1'b1;
                            state <= SC_ISSUE;
                        end
                    end
                end
                default: state <= SC_DONE;
            endcase
        end
    end

    assign rd_req    = (state == SC_ISSUE);
    assign rd_block  = blk;
    assign rd_page   = {{(PAGE_W-1){1'b0}}, pg};
    assign rd_col    = COL_W'(SPARE_COL);
    assign set_en    = (state == SC_WAIT) && rsp_valid && vd.settle && vd.bad;
    assign set_block = blk;
    assign done      = (state == SC_DONE);

endmodule

// File: rtl/bst_mark_hold.sv
module bst_mark_hold #(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_done,
    input  logic             mark_valid,
    input  logic [BLK_W-1:0] mark_block,
    output logic             set_en,
    output logic [BLK_W-1:0] set_block
);

    logic             pend_v;
    logic [BLK_W-1:0] pend_blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_blk <= '0;
        end else if (!scan_done) begin
            if (mark_valid && !pend_v) begin
                pend_v   <= 1'b1;
                pend_blk <= mark_block;
            end
        end else if (pend_v) begin
            // Held entry drains now; a new mark takes its place.
            pend_v <= mark_valid;
            if (mark_valid) begin
                pend_blk <= mark_block;
            end
        end
    end

    always_comb begin
        set_en    = scan_done && (pend_v || mark_valid);
        set_block = pend_v ? pend_blk : mark_block;
    end

endmodule

// File: rtl/bst_table.sv
module bst_table #(
    parameter int NUM_BLOCKS = 1024,
    parameter int BLK_W      = 10,
    parameter int CNT_W      = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_block,
    input  logic [BLK_W-1:0] lk_block,
    output logic             lk_bad,
    output logic [CNT_W-1:0] bad_count
);

    logic [NUM_BLOCKS-1:0] bad_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_map   <= '0;
            bad_count <= '0;
            lk_bad    <= 1'b0;
        end else begin
            lk_bad <= bad_map[lk_block];
            if (set_en && !bad_map[set_block]) begin
                bad_map[set_block] <= 1'b1;
                bad_count          <= bad_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bst_scanner.sv
module bst_scanner #(
    parameter int  NUM_BLOCKS      = 1024,
    parameter int  PAGES_PER_BLOCK = 64,
    parameter int  COL_W           = 12,
    parameter int  SPARE_COL       = 2048,
    localparam int BLK_W           = $clog2(NUM_BLOCKS),
    localparam int PAGE_W          = $clog2(PAGES_PER_BLOCK),
    localparam int CNT_W           = $clog2(NUM_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_req,
    output logic [BLK_W-1:0]  rd_block,
    output logic [PAGE_W-1:0] rd_page,
    output logic [COL_W-1:0]  rd_col,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    input  logic [BLK_W-1:0]  lk_block,
    output logic              lk_bad,
    input  logic              mark_valid,
    input  logic [BLK_W-1:0]  mark_block,
    output logic              scan_done,
    output logic [CNT_W-1:0]  bad_count
);

    logic             scan_set;
    logic [BLK_W-1:0] scan_set_blk;
    logic             mk_set;
    logic [BLK_W-1:0] mk_set_blk;
    logic             tbl_set;
    logic [BLK_W-1:0] tbl_set_blk;

    bst_scan_seq #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W),
        .PAGE_W    (PAGE_W),
        .COL_W     (COL_W),
        .SPARE_COL (SPARE_COL)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rsp_valid(rd_rsp_valid),
        .rsp_data (rd_rsp_data),
        .rd_req   (rd_req),
        .rd_block (rd_block),
        .rd_page  (rd_page),
        .rd_col   (rd_col),
        .set_en   (scan_set),
        .set_block(scan_set_blk),
        .done     (scan_done)
    );

    bst_mark_hold #(
        .BLK_W(BLK_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .scan_done (scan_done),
        .mark_valid(mark_valid),
        .mark_block(mark_block),
        .set_en    (mk_set),
        .set_block (mk_set_blk)
    );

    // Scan writes occur only before done, mark writes only after.
    assign tbl_set     = scan_set || mk_set;
    assign tbl_set_blk = scan_done ? mk_set_blk : scan_set_blk;

    bst_table #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W),
        .CNT_W     (CNT_W)
    ) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .set_en   (tbl_set),
        .set_block(tbl_set_blk),
        .lk_block (lk_block),
        .lk_bad   (lk_bad),
        .bad_count(bad_count)
    );

endmodule

// File: rtl/bst_scanner_chk.sv
module bst_scanner_chk #(
    parameter int BLK_W  = 10,
    parameter int PAGE_W = 6,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic [BLK_W-1:0]  rd_block,
    input logic [PAGE_W-1:0] rd_page,
    input logic              rd_rsp_valid,
    input logic              scan_done,
    input logic [CNT_W-1:0]  bad_count
);

    AST_BLOCK0_NEVER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_block != '0); // R1

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !rd_rsp_valid |=> $stable(rd_block) && $stable(rd_page)); // R2

    AST_PAGE1_SAME_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_page != '0) |-> rd_block == $past(rd_block)); // R4

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !rd_req); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> scan_done); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bad_count == $past(bad_count)) ||
                 (bad_count == $past(bad_count) + CNT_W'(1))); // R7

endmodule

bind bst_scanner bst_scanner_chk #(
    .BLK_W (BLK_W),
    .PAGE_W(PAGE_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (rd_req),
    .rd_block    (rd_block),
    .rd_page     (rd_page),
    .rd_rsp_valid(rd_rsp_valid),
    .scan_done   (scan_done),
    .bad_count   (bad_count)
);

// File: tb/tb_bst_scanner.sv
module tb_bst_scanner;

    localparam int NB    = 64;
    localparam int BW    = 6;
    localparam int PW    = 6;
    localparam int CW    = 12;
    localparam int CNTW  = 7;
    localparam int SPARE = 2048;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rd_req;
    logic [BW-1:0]   rd_block;
    logic [PW-1:0]   rd_page;
    logic [CW-1:0]   rd_col;
    logic            rd_rsp_valid = 1'b0;
    logic [7:0]      rd_rsp_data = 8'h00;
    logic [BW-1:0]   lk_block = '0;
    logic            lk_bad;
    logic            mark_valid = 1'b0;
    logic [BW-1:0]   mark_block = '0;
    logic            scan_done;
    logic [CNTW-1:0] bad_count;

    always #10 clk = ~clk;

    bst_scanner #(
        .NUM_BLOCKS     (NB),
        .PAGES_PER_BLOCK(64),
        .COL_W          (CW),
        .SPARE_COL      (SPARE)
    ) dut (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_block(rd_block), .rd_page(rd_page), .rd_col(rd_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .lk_block(lk_block), .lk_bad(lk_bad),
        .mark_valid(mark_valid), .mark_block(mark_block),
        .scan_done(scan_done), .bad_count(bad_count)
    );

    // flash marker contents and reference model state
    logic [7:0] m0 [NB];
    logic [7:0] m1 [NB];
    bit  mtab [NB];
    int  mcount;
    bit  mdone, mlk, mexp_req, mpend_v, waiting;
    int  mpend_b, cur_blk, cur_pg, lat;
    int  q_blk[$];
    int  q_pg[$];
    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic mset(input int b);
        if (!mtab[b]) begin
            mtab[b] = 1'b1;
            mcount++;
        end
    endtask

    task automatic build_queue();
        q_blk.delete();
        q_pg.delete();
        for (int b = 1; b < NB; b++) begin
            q_blk.push_back(b); q_pg.push_back(0);
            if (m0[b] == 8'hFF) begin
                q_blk.push_back(b); q_pg.push_back(1);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mark_valid = 1'b0; rd_rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!scan_done, "R1", "done in reset", scan_done, 0);
        chk(bad_count == 0, "R1", "count in reset", bad_count, 0);
        chk(!lk_bad, "R1", "lookup in reset", lk_bad, 0);
        chk(!rd_req, "R1", "request in reset", rd_req, 0);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) mtab[b] = 1'b0;
        mcount = 0; mdone = 0; mlk = 0; mpend_v = 0; mexp_req = 1; waiting = 0;
        build_queue();
    endtask

    task automatic step(input bit mk, input int mkb, input int lkb);
        bit mlk_n;
        logic [7:0] d;
        bit bad;
        @(negedge clk);
        chk(rd_req == mexp_req, "R2", "read request", rd_req, mexp_req);
        if (rd_req) begin
            if (q_blk.size() == 0) begin
                chk(0, "R5", "read after last block", rd_block, -1);
            end else begin
                chk(rd_block == q_blk[0], q_pg[0] != 0 ? "R4" : "R3", "read block",
                    rd_block, q_blk[0]);
                chk(rd_page == q_pg[0], q_pg[0] != 0 ? "R4" : "R3", "read page",
                    rd_page, q_pg[0]);
                chk(rd_col == SPARE, "R2", "read column", rd_col, SPARE);
            end
        end
        if (waiting) begin
            chk(rd_block == cur_blk, "R2", "block held", rd_block, cur_blk);
            chk(rd_page == cur_pg, "R2", "page held", rd_page, cur_pg);
        end
        chk(scan_done == mdone, "R5", "scan done", scan_done, mdone);
        chk(bad_count == mcount, "R7", "bad count", bad_count, mcount);
        chk(lk_bad == mlk, "R6", "lookup", lk_bad, mlk);

        lk_block = BW'(lkb); mark_valid = mk; mark_block = BW'(mkb);
        rd_rsp_valid = 1'b0; rd_rsp_data = 8'($urandom);
        mlk_n = mtab[lkb];
        if (!mdone) begin
            if (mk && !mpend_v) begin mpend_v = 1; mpend_b = mkb; end
        end else if (mpend_v) begin
            mset(mpend_b);
            mpend_v = mk;
            if (mk) mpend_b = mkb;
        end else if (mk) begin
            mset(mkb);
        end
        if (rd_req && q_blk.size() > 0) begin
            cur_blk = q_blk.pop_front(); cur_pg = q_pg.pop_front();
            waiting = 1; lat = $urandom_range(1, 3); mexp_req = 0;
        end else if (waiting) begin
            lat--;
            if (lat == 0) begin
                d = (cur_pg != 0) ? m1[cur_blk] : m0[cur_blk];
                rd_rsp_valid = 1'b1; rd_rsp_data = d; waiting = 0;
                bad = (d != 8'hFF);
                if (bad || cur_pg != 0) begin
                    if (bad) mset(cur_blk);
                    if (cur_blk == NB - 1) mdone = 1;
                    else mexp_req = 1;
                end else begin
                    mexp_req = 1;
                end
            end
        end
        mlk = mlk_n;
    endtask

    task automatic look(input int b, input bit exp, input string tag);
        step(0, 0, b);
        step(0, 0, 0);
        chk(lk_bad == exp, tag, $sformatf("lookup block %0d", b), lk_bad, exp);
    endtask

    task automatic run_to_done();
        int n = 0;
        while (!mdone && n < 20000) begin
            step(0, 0, $urandom_range(0, NB - 1));
            n++;
        end
        step(0, 0, 0);
        step(0, 0, 0);
    endtask

    task automatic fill_erased();
        for (int b = 0; b < NB; b++) begin m0[b] = 8'hFF; m1[b] = 8'hFF; end
    endtask

    initial begin
        // scenario A
        fill_erased();
        m0[0] = 8'h00;                       // block 0 never read
        m0[3] = 8'h00; m0[10] = 8'hFE; m0[20] = 8'h7F;
        m1[5] = 8'h00; m1[11] = 8'hF7; m1[63] = 8'h80;
        m1[3] = 8'h00;                       // must not matter, page 1 skipped
        do_reset();
        for (int c = 0; !mdone && c < 20000; c++) begin
            step((c == 20) || (c == 40), (c == 20) ? 30 : 31, $urandom_range(0, NB - 1));
        end
        step(0, 0, 0);
        step(0, 0, 0);
        look(30, 1, "R9 held mark");
        look(31, 0, "R9 dropped mark");
        look(0, 0, "R1 block 0");
        look(3, 1, "R3 page0 bad");
        look(10, 1, "R3 page0 FE");
        look(5, 1, "R4 page1 bad");
        look(6, 0, "R4 erased good");
        look(63, 1, "R5 last block");
        chk(bad_count == 7, "R7", "count after scan", bad_count, 7);

        step(1, 3, 0);
        step(0, 0, 0);
        chk(bad_count == 7, "R7", "remark bad block", bad_count, 7);
        step(1, 40, 0);
        step(1, 41, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        chk(bad_count == 10, "R8", "count after marks", bad_count, 10);
        look(40, 1, "R8 mark 40");
        look(41, 1, "R8 mark 41");
        look(0, 1, "R8 mark block 0");
        step(1, 44, 44);
        step(0, 0, 44);
        chk(lk_bad == 0, "R6", "same-edge lookup old value", lk_bad, 0);
        step(0, 0, 0);
        chk(lk_bad == 1, "R8", "mark visible next edge", lk_bad, 1);

        // scenario B with an interrupted scan
        fill_erased();
        m0[1] = 8'h00; m1[62] = 8'h7F;
        do_reset();
        step(0, 0, 0);
        chk(rd_req && rd_block == 1 && rd_page == 0, "R10", "first read", rd_block, 1);
        for (int i = 0; i < 30; i++) step(i == 5, 50, 0);
        do_reset();
        step(0, 0, 0);
        chk(rd_req && rd_block == 1 && rd_page == 0, "R10", "restart read", rd_block, 1);
        run_to_done();
        chk(bad_count == 2, "R10", "count after restart", bad_count, 2);
        look(50, 0, "R10 held mark cleared");
        look(30, 0, "R10 table cleared");
        look(1, 1, "R3 block 1");
        look(62, 1, "R4 block 62");
        look(63, 0, "R5 last block good");

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule